// File: doc/BRIEF.md
# Double-Buffered Converter Code Register

This block holds the code for a 14-bit bipolar converter in two stages. A staging register takes a whole word from a parallel bus while a select and a write strobe are both low. It keeps that word when either strobe goes high. A second register feeds the converter. It copies the staging register while a separate load strobe is low, so software can write ahead and commit the new code at a time it chooses. The two registers are interlocked: while a write is in progress the converter register does not move. If the load strobe is tied low, each write therefore commits itself at the moment the write ends.

All strobes are asynchronous and active low. They pass through synchronizer flops clocked by the system clock. The data bus passes through the same number of flops, so data stays aligned with the strobes. "Following" a value means reloading it on every clock while the enabling condition holds. Codes are two's complement: 0x1FFF is the most positive code, 0x2000 is the most negative, and 0x0000 is mid-scale. A one-clock `code_upd` pulse marks every change of the converter code.

Top module: `dbuf_dac_ctrl`

## Requirements
- R1: Reset (synchronous, `rst_n` low) clears the staging register and the converter code to 0x0000 and holds `code_upd` low. This applies at start-up and also in the middle of operation.
- R2: While `sel_n` and `wstb_n` are both low, the staging register follows `bus_data`. When either one is high, it keeps its last value, whatever `load_n` does.
- R3: While `load_n` is low and no write is in progress, `dac_code` follows the staging register. While `load_n` is high, `dac_code` holds.
- R4: While a write is in progress (`sel_n` and `wstb_n` both low), `dac_code` holds even if `load_n` is low.
- R5: With `load_n` held low, `dac_code` takes the last written word as soon as `sel_n` or `wstb_n` returns high.
- R6: `code_upd` is high for exactly one clock each time `dac_code` changes, in the same clock as the change. It stays low when a reload leaves the value unchanged.
- R7: All 14 bits move together with no reordering. Bit 13 is the sign bit and bit 0 the LSB, so 0x1FFF, 0x2000 and 0x3FFF all reach `dac_code` unchanged.
- R8: With the default two synchronizer stages, suppose `load_n` falls between clock edges while the staging register holds a new word. Then `dac_code` and `code_upd` change after the third rising edge, not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Chip select, active low, asynchronous |
| wstb_n | input | 1 | Write strobe, active low, asynchronous |
| load_n | input | 1 | Converter load strobe, active low, asynchronous |
| bus_data | input | 14 | Parallel code word, two's complement |
| dac_code | output | 14 | Code presented to the converter |
| code_upd | output | 1 | One-clock pulse on each change of `dac_code` |

## Verification
A sequence of strobe patterns is applied, and each one separates one behaviour from a near neighbour:
- A write with the load strobe high separates staging from committing.
- A lone select or a lone write strobe separates a real write from a half-asserted one. The effect is checked through a later load.
- Writes with the load strobe already low show the interlock: the code stays frozen during the write and jumps at its end, whether the select or the write strobe ends it.

Extreme codes (most positive, most negative, all ones) check bit integrity. A reload of an equal value separates a real change from a mere reload in the pulse count. A timed load edge fixes the exact latency, and a reset in mid-operation checks the clear.

// File: rtl/dbuf_pkg.sv
// Shared widths and types for the double-buffered converter code register.
// Assumes: codes are two's complement, bit CODE_W-1 is the sign bit.
package dbuf_pkg;
    parameter int CODE_W = 14;   // converter code width
    parameter int SYNC_N = 2;    // synchronizer depth for strobes and data
    localparam int CTRL_W = 3;   // number of strobes: select, write, load

    typedef logic [CODE_W-1:0] code_t;

    // Strobe positions inside the synchronized control vector
    localparam int IDX_SEL  = 0;
    localparam int IDX_WSTB = 1;
    localparam int IDX_LOAD = 2;
endpackage

// File: rtl/dbuf_sync.sv
// Multi-stage synchronizer for a bus of asynchronous signals.
// Each bit runs through STAGES flops. The reset value is chosen so that
// reset leaves the synchronized value in its inactive state.
// Assumes: bits of one bus are sampled together, and the width is not
// treated as a coherent word across a change (the caller delays data to match).
module dbuf_sync #(
    parameter int    WIDTH   = 1,
    parameter int    STAGES  = 2,
    parameter logic  RST_BIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam logic [WIDTH-1:0] RST_VEC = {WIDTH{RST_BIT}};

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop samples the asynchronous input
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VEC;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_next
                // Later flops pass the value along
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VEC;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/dbuf_in_latch.sv
// Staging register. It reloads from the data bus on every clock while a
// write is in progress and holds otherwise.
// Assumes: the write qualifier and the data are already synchronized and aligned.
module dbuf_in_latch
    import dbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_act,
    input  code_t wr_data,
    output code_t stage_code
);
    code_t stage_q;

    // Follow the bus during a write, keep the last value afterwards
    always_ff @(posedge clk) begin
        if (!rst_n)      stage_q <= '0;
        else if (wr_act) stage_q <= wr_data;
    end

    assign stage_code = stage_q;

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_act |=> $stable(stage_q)); // R2
    AST_STAGE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_act |=> (stage_q == $past(wr_data))); // R2
endmodule

// File: rtl/dbuf_out_latch.sv
// Converter register. It reloads from the staging register while the load
// strobe is active and no write is in progress. The interlock keeps the two
// registers from following their sources at the same time. It also raises
// a one-clock pulse whenever the stored code changes.
// Assumes: synchronized inputs, and stage_code driven by dbuf_in_latch.
module dbuf_out_latch
    import dbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ld_act,
    input  logic  wr_act,
    input  code_t stage_code,
    output code_t out_code,
    output logic  out_upd
);
    code_t out_q;
    code_t out_next;
    logic  upd_q;
    logic  copy_en;

    // Interlock: a copy is allowed only when no write is in progress
    always_comb begin
        copy_en  = ld_act && !wr_act;
        out_next = copy_en ? stage_code : out_q;
    end

    // Register the code and flag a change of value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            upd_q <= 1'b0;
        end else begin
            out_q <= out_next;
            upd_q <= (out_next != out_q);
        end
    end

    assign out_code = out_q;
    assign out_upd  = upd_q;

    AST_FREEZE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_act |=> $stable(out_q)); // R4
    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_act |=> $stable(out_q)); // R3
    AST_COPY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_act && !wr_act) |=> (out_q == $past(stage_code))); // R3
    AST_PULSE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q |-> !$stable(out_q)); // R6
    AST_CHANGE_MEANS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_q |-> $stable(out_q)); // R6
endmodule

// File: rtl/dbuf_dac_ctrl.sv
// Top of the double-buffered converter code register. It synchronizes the
// active-low strobes, delays the data bus by the same depth, and drives
// the staging and converter registers.
// Assumes: strobes are asynchronous to clk, and bus_data is stable while the
// write strobes rise (setup and hold longer than one clock).
module dbuf_dac_ctrl
    import dbuf_pkg::*;
#(
    parameter int WIDTH = CODE_W,
    parameter int SYNC  = SYNC_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             wstb_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] bus_data,
    output logic [WIDTH-1:0] dac_code,
    output logic             code_upd
);
    logic [CTRL_W-1:0] ctrl_raw;
    logic [CTRL_W-1:0] ctrl_s;
    code_t             data_s;
    code_t             stage_code;
    logic              wr_act;
    logic              ld_act;

    // Gather the strobes into one vector for the synchronizer
    always_comb begin
        ctrl_raw           = '1;
        ctrl_raw[IDX_SEL]  = sel_n;
        ctrl_raw[IDX_WSTB] = wstb_n;
        ctrl_raw[IDX_LOAD] = load_n;
    end

    dbuf_sync #(.WIDTH(CTRL_W), .STAGES(SYNC), .RST_BIT(1'b1)) u_ctrl_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ctrl_raw),
        .sync_out (ctrl_s)
    );

    dbuf_sync #(.WIDTH(CODE_W), .STAGES(SYNC), .RST_BIT(1'b0)) u_data_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (code_t'(bus_data)),
        .sync_out (data_s)
    );

    // Decode the level conditions from the synchronized strobes
    always_comb begin
        wr_act = !ctrl_s[IDX_SEL] && !ctrl_s[IDX_WSTB];
        ld_act = !ctrl_s[IDX_LOAD];
    end

    dbuf_in_latch u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_act     (wr_act),
        .wr_data    (data_s),
        .stage_code (stage_code)
    );

    dbuf_out_latch u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_act     (ld_act),
        .wr_act     (wr_act),
        .stage_code (stage_code),
        .out_code   (dac_code),
        .out_upd    (code_upd)
    );

    AST_AUTO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_act) && !wr_act && ld_act) |=> (dac_code == $past(stage_code))); // R5
endmodule

// File: tb/tb_dbuf_dac_ctrl.sv
`timescale 1ns/1ps
// Bench for dbuf_dac_ctrl: a vector table walked by one loop, then directed
// tests for latency, reset and the pulse.
module tb_dbuf_dac_ctrl;
    localparam int W = 14;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         sel_n, wstb_n, load_n;
    logic [W-1:0] bus_data;
    logic [W-1:0] dac_code;
    logic         code_upd;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk; // 125 MHz

    dbuf_dac_ctrl dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .wstb_n   (wstb_n),
        .load_n   (load_n),
        .bus_data (bus_data),
        .dac_code (dac_code),
        .code_upd (code_upd)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Row: {sel_n, wstb_n, load_n, data[13:0], expected dac_code[13:0], req no.[3:0]}
    localparam int NV = 14;
    localparam logic [34:0] VEC [NV] = '{
        {3'b111, 14'h1234, 14'h0000, 4'd2}, // R2 no write
        {3'b001, 14'h1FFF, 14'h0000, 4'd3}, // R3 load high holds
        {3'b111, 14'h0AAA, 14'h0000, 4'd2}, // R2 strobes high
        {3'b110, 14'h0AAA, 14'h1FFF, 4'd7}, // R7 most positive code
        {3'b111, 14'h0000, 14'h1FFF, 4'd3}, // R3 hold
        {3'b011, 14'h2000, 14'h1FFF, 4'd2}, // R2 select only (sel_n=0)
        {3'b101, 14'h2000, 14'h1FFF, 4'd2}, // R2 write strobe only
        {3'b110, 14'h2000, 14'h1FFF, 4'd2}, // R2 staging unchanged, seen via load
        {3'b000, 14'h2000, 14'h1FFF, 4'd4}, // R4 frozen during write
        {3'b000, 14'h3FFF, 14'h1FFF, 4'd4}, // R4 still frozen
        {3'b100, 14'h3FFF, 14'h3FFF, 4'd5}, // R5 select ends write
        {3'b000, 14'h2000, 14'h3FFF, 4'd4}, // R4
        {3'b010, 14'h1555, 14'h2000, 4'd5}, // R5 write strobe ends write, R7 most negative
        {3'b111, 14'h0001, 14'h2000, 4'd3}  // R3 hold
    };

    // Watchdog: a hang is a failed check
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] prev_exp;
        rst_n = 1'b0; sel_n = 1'b1; wstb_n = 1'b1; load_n = 1'b1; bus_data = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset code", int'(dac_code), 0);
        chk("R1 reset pulse", int'(code_upd), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        prev_exp = '0;
        for (int i = 0; i < NV; i++) begin
            int pulses;
            logic [W-1:0] exp_code;
            pulses = 0;
            {sel_n, wstb_n, load_n} = VEC[i][34:32];
            bus_data = VEC[i][31:18];
            exp_code = VEC[i][17:4];
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (code_upd) pulses++;
            end
            chk($sformatf("R%0d row %0d code", VEC[i][3:0], i), int'(dac_code), int'(exp_code));
            // R6: one pulse per change, none otherwise
            chk($sformatf("R6 row %0d pulses", i), pulses, (exp_code != prev_exp) ? 1 : 0);
            prev_exp = exp_code;
        end

        // R6: reload of an equal value raises no pulse
        begin
            int pulses;
            pulses = 0;
            load_n = 1'b0;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (code_upd) pulses++;
            end
            chk("R6 equal reload no pulse", pulses, 0);
            load_n = 1'b1;
            repeat (3) @(negedge clk);
        end

        // R8: exact latency from a falling load strobe
        sel_n = 1'b0; wstb_n = 1'b0; bus_data = 14'h0123;
        repeat (5) @(negedge clk);
        sel_n = 1'b1; wstb_n = 1'b1;
        repeat (4) @(negedge clk);
        load_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 not before third edge", int'(dac_code), 16'h2000);
        chk("R8 no early pulse", int'(code_upd), 0);
        @(negedge clk);
        chk("R8 code at third edge", int'(dac_code), 16'h0123);
        chk("R8 pulse at third edge", int'(code_upd), 1);
        @(negedge clk);
        chk("R6 pulse lasts one clock", int'(code_upd), 0);

        // R1: reset in mid-operation
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 mid reset code", int'(dac_code), 0);
        chk("R1 mid reset pulse", int'(code_upd), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 staging cleared by reset", int'(dac_code), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule